// File: doc/BRIEF.md
# Local-History Branch Direction Predictor

This block guesses whether a conditional branch will be taken. Each branch address maps to one slot of a history table. A slot keeps a partial tag and a short shift register of that branch's recent outcomes. All branches share a single array of 2-bit saturating counters. The lookup port sends a branch address, and one cycle later the block returns a taken or not-taken guess, a hit flag and the counter index it used.

When the branch resolves, the update port sends the address, the real outcome and that same counter index. The block trains the counter at that index and shifts the outcome into the branch's history. Training therefore reaches the counter the guess came from, even if the branch's history has moved on since.

A mode input sets how the counter index is formed. In append mode, low address bits sit below the history, which gives each branch its own region of the array. In XOR mode, the history is folded with address bits, so only the lower part of the array is used.

Top module: `lhist_dir_pred`

## Requirements
- R1: After reset `pr_valid` is 0 and every counter holds 2'b10 (weakly taken). So the first tag-hit lookup of an untrained counter predicts taken.
- R2: A lookup presented with `lk_valid` high at a clock edge yields `pr_valid` high for exactly the following cycle, with that lookup's result.
- R3: On a tag hit (the slot at `lk_pc[9:0]` is valid and its tag equals `lk_pc[17:10]`), `pr_hit` is 1 and `pr_taken` is bit 1 of the selected counter.
- R4: On a tag miss, `pr_hit` is 0 and `pr_taken` is 0. `pr_cidx` is formed as if the history were all zero.
- R5: With `idx_xor` = 0, `pr_cidx` = {history[5:0], `lk_pc[1:0]`}.
- R6: With `idx_xor` = 1, `pr_cidx` = {2'b00, history[5:0] XOR `lk_pc[5:0]`}.
- R7: A resolution whose address hits its slot sets the history to {old history[4:0], `up_taken`}. The newest outcome goes in at bit 0 and the oldest bit is dropped.
- R8: A resolution whose address misses its slot claims the slot. The tag is set to `up_pc[17:10]`, the history is cleared and then takes `up_taken` at bit 0. Any earlier branch held in that slot is replaced.
- R9: A taken resolution increments the counter at `up_cidx`. A counter at 2'b11 stays at 2'b11.
- R10: A not-taken resolution decrements the counter at `up_cidx`. A counter at 2'b00 stays at 2'b00.
- R11: The trained counter is the one named by `up_cidx`, whatever the current history of `up_pc` is.
- R12: A branch whose outcomes repeat the period-4 pattern 0,0,0,1 is, once warmed up, predicted correctly every time. It is predicted taken only after the history 6'b001000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idx_xor | input | 1 | Index mode for lookups: 0 appends address bits, 1 XORs them |
| lk_valid | input | 1 | Lookup request |
| lk_pc | input | 18 | Branch address to predict |
| up_valid | input | 1 | Resolution request |
| up_pc | input | 18 | Address of the resolved branch |
| up_taken | input | 1 | Actual outcome, 1 = taken |
| up_cidx | input | 8 | Counter index returned by the lookup of this branch |
| pr_valid | output | 1 | Prediction result valid |
| pr_taken | output | 1 | Predicted direction |
| pr_hit | output | 1 | History table tag hit |
| pr_cidx | output | 8 | Counter index used for this prediction |

## Verification
A lookup driven at a falling edge is registered at the next rising edge. Its result is sampled at the falling edge after that, so the scoreboard takes each queued expectation exactly one cycle after the request. A resolution changes state at the rising edge inside its one-cycle pulse. Its effect is visible only through a later lookup, so every training step is followed by a lookup whose expected result includes that change. Saturation and the stale-index rule are both observed this way. Counters are trained under one branch address and then read through another, which shows the counter limits at the lookup port.

// File: rtl/lhp_pkg.sv
package lhp_pkg;
    localparam logic [1:0] CTR_STRONG_NT = 2'b00;
    localparam logic [1:0] CTR_WEAK_NT   = 2'b01;
    localparam logic [1:0] CTR_WEAK_T    = 2'b10;
    localparam logic [1:0] CTR_STRONG_T  = 2'b11;
    localparam logic [1:0] CTR_INIT      = CTR_WEAK_T;
endpackage

// File: rtl/lhp_index.sv
module lhp_index #(
    parameter int HIST_W   = 6,
    parameter int CAT_BITS = 2
) (
    input  logic [HIST_W-1:0]          hist,
    input  logic [HIST_W-1:0]          addr,
    input  logic                       xor_mode,
    output logic [HIST_W+CAT_BITS-1:0] cidx
);
    generate
        if (CAT_BITS > 0) begin : g_cat
            always_comb begin
                if (xor_mode) cidx = {{CAT_BITS{1'b0}}, hist ^ addr};
                else          cidx = {hist, addr[CAT_BITS-1:0]};
            end
        end else begin : g_nocat
            always_comb cidx = xor_mode ? (hist ^ addr) : hist;
        end
    endgenerate
endmodule

// File: rtl/lhp_ctr_step.sv
module lhp_ctr_step
    import lhp_pkg::*;
(
    input  logic [1:0] cur,
    input  logic       taken,
    output logic [1:0] nxt
);
    always_comb begin
        nxt = cur;
        if (taken) begin
            if (cur != CTR_STRONG_T) nxt = cur + 2'd1;
        end else begin
            if (cur != CTR_STRONG_NT) nxt = cur - 2'd1;
        end
    end
endmodule

// File: rtl/lhist_dir_pred.sv
module lhist_dir_pred
    import lhp_pkg::*;
#(
    parameter int HT_ENTRIES = 1024,
    parameter int TAG_W      = 8,
    parameter int HIST_W     = 6,
    parameter int CAT_BITS   = 2,
    localparam int HT_IDX_W  = $clog2(HT_ENTRIES),
    localparam int PC_W      = HT_IDX_W + TAG_W,
    localparam int CIDX_W    = HIST_W + CAT_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idx_xor,
    input  logic              lk_valid,
    input  logic [PC_W-1:0]   lk_pc,
    input  logic              up_valid,
    input  logic [PC_W-1:0]   up_pc,
    input  logic              up_taken,
    input  logic [CIDX_W-1:0] up_cidx,
    output logic              pr_valid,
    output logic              pr_taken,
    output logic              pr_hit,
    output logic [CIDX_W-1:0] pr_cidx
);
    localparam int CTR_N = 1 << CIDX_W;

    typedef struct packed {
        logic              vld;
        logic [TAG_W-1:0]  tag;
        logic [HIST_W-1:0] hist;
    } ht_ent_t;

    typedef struct packed {
        logic              vld;
        logic              taken;
        logic              hit;
        logic [CIDX_W-1:0] cidx;
    } pred_t;

    ht_ent_t    ht_q  [HT_ENTRIES];
    ht_ent_t    ht_d  [HT_ENTRIES];
    logic [1:0] ctr_q [CTR_N];
    logic [1:0] ctr_d [CTR_N];
    pred_t      pred_q, pred_d;

    logic [HT_IDX_W-1:0] lk_set, up_set;
    logic [TAG_W-1:0]    lk_tag, up_tag;
    ht_ent_t             lk_ent, up_ent;
    logic                lk_hit, up_hit;
    logic [HIST_W-1:0]   lk_hist_eff;
    logic [CIDX_W-1:0]   lk_cidx;
    logic [1:0]          up_ctr_nxt;
    logic [HIST_W:0]     up_shift;

    assign lk_set = lk_pc[HT_IDX_W-1:0];
    assign lk_tag = lk_pc[HT_IDX_W +: TAG_W];
    assign up_set = up_pc[HT_IDX_W-1:0];
    assign up_tag = up_pc[HT_IDX_W +: TAG_W];
    assign lk_ent = ht_q[lk_set];
    assign up_ent = ht_q[up_set];
    assign lk_hit = lk_ent.vld && (lk_ent.tag == lk_tag);
    assign up_hit = up_ent.vld && (up_ent.tag == up_tag);
    assign lk_hist_eff = lk_hit ? lk_ent.hist : '0;
    assign up_shift = {up_ent.hist, up_taken};

    lhp_index #(.HIST_W(HIST_W), .CAT_BITS(CAT_BITS)) u_index (
        .hist     (lk_hist_eff),
        .addr     (lk_pc[HIST_W-1:0]),
        .xor_mode (idx_xor),
        .cidx     (lk_cidx)
    );

    lhp_ctr_step u_step (
        .cur   (ctr_q[up_cidx]),
        .taken (up_taken),
        .nxt   (up_ctr_nxt)
    );

    always_comb begin
        ht_d   = ht_q;
        ctr_d  = ctr_q;
        pred_d = '0;
        if (lk_valid) begin
            pred_d.vld   = 1'b1;
            pred_d.hit   = lk_hit;
            pred_d.cidx  = lk_cidx;
            pred_d.taken = lk_hit && ctr_q[lk_cidx][1];
        end
        if (up_valid) begin
            ctr_d[up_cidx] = up_ctr_nxt;
            if (up_hit) begin
                ht_d[up_set].hist = up_shift[HIST_W-1:0];
            end else begin
                ht_d[up_set].vld  = 1'b1;
                ht_d[up_set].tag  = up_tag;
                ht_d[up_set].hist = {{(HIST_W-1){1'b0}}, up_taken};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pred_q <= '0;
            for (int i = 0; i < HT_ENTRIES; i++) ht_q[i] <= '0;
            for (int i = 0; i < CTR_N; i++) ctr_q[i] <= CTR_INIT;
        end else begin
            pred_q <= pred_d;
            ht_q   <= ht_d;
            ctr_q  <= ctr_d;
        end
    end

    assign pr_valid = pred_q.vld;
    assign pr_taken = pred_q.taken;
    assign pr_hit   = pred_q.hit;
    assign pr_cidx  = pred_q.cidx;

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> pr_valid);
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !pr_valid);
    a_r4_miss_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (pr_valid && !pr_hit) |-> !pr_taken);
    a_r8_alloc_tag: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && !up_hit) |=>
            (ht_q[$past(up_set)].vld && ht_q[$past(up_set)].tag == $past(up_tag)));
    a_r7_hist_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_hit) |=>
            (ht_q[$past(up_set)].hist[0] == $past(up_taken)));
    a_r9_sat_high: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_taken && ctr_q[up_cidx] == CTR_STRONG_T) |=>
            (ctr_q[$past(up_cidx)] == CTR_STRONG_T));
    a_r10_sat_low: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && !up_taken && ctr_q[up_cidx] == CTR_STRONG_NT) |=>
            (ctr_q[$past(up_cidx)] == CTR_STRONG_NT));
    generate
        if (CAT_BITS > 0) begin : g_xor_chk
            a_r6_xor_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
                (lk_valid && idx_xor) |=> (pr_cidx[CIDX_W-1 -: CAT_BITS] == '0));
        end
    endgenerate
endmodule

// File: tb/lhist_dir_pred_tb.sv
module lhist_dir_pred_tb;
    localparam int CTR_N = 256;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       idx_xor = 1'b0;
    logic       lk_valid = 1'b0;
    logic [17:0] lk_pc = '0;
    logic       up_valid = 1'b0;
    logic [17:0] up_pc = '0;
    logic       up_taken = 1'b0;
    logic [7:0] up_cidx = '0;
    logic       pr_valid, pr_taken, pr_hit;
    logic [7:0] pr_cidx;

    int n_checks = 0;
    int n_fail   = 0;

    typedef struct {
        logic       taken;
        logic       hit;
        logic [7:0] cidx;
        string      req;
    } exp_t;
    exp_t q[$];

    // expectation state built from the requirements
    logic       m_vld  [1024];
    logic [7:0] m_tag  [1024];
    logic [5:0] m_hist [1024];
    logic [1:0] m_ctr  [CTR_N];

    always #4 clk = ~clk;

    lhist_dir_pred u_dut (
        .clk(clk), .rst_n(rst_n), .idx_xor(idx_xor),
        .lk_valid(lk_valid), .lk_pc(lk_pc),
        .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken), .up_cidx(up_cidx),
        .pr_valid(pr_valid), .pr_taken(pr_taken), .pr_hit(pr_hit), .pr_cidx(pr_cidx)
    );

    task automatic check(input bit ok, input string req, input string act, input string exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%s expected=%s", req, act, exp);
        end
    endtask

    function automatic logic [7:0] m_index(input logic [5:0] h, input logic [17:0] pc, input logic xr);
        if (xr) return {2'b00, h ^ pc[5:0]};  // R6
        return {h, pc[1:0]};                   // R5
    endfunction

    // driver: one lookup, expected result pushed to the scoreboard
    task automatic lookup(input logic [17:0] pc, input logic xr, input string req,
                          output logic [7:0] cidx, input int force_taken = -1);
        exp_t e;
        logic hit;
        hit  = m_vld[pc[9:0]] && (m_tag[pc[9:0]] == pc[17:10]);
        cidx = m_index(hit ? m_hist[pc[9:0]] : 6'd0, pc, xr);
        e.hit   = hit;
        e.cidx  = cidx;
        e.taken = hit && m_ctr[cidx][1];
        if (force_taken >= 0) e.taken = force_taken[0];
        e.req = req;
        @(negedge clk);
        q.push_back(e);
        lk_valid = 1'b1; lk_pc = pc; idx_xor = xr;
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    task automatic resolve(input logic [17:0] pc, input logic tk, input logic [7:0] cidx);
        logic [9:0] s;
        s = pc[9:0];
        @(negedge clk);
        up_valid = 1'b1; up_pc = pc; up_taken = tk; up_cidx = cidx;
        @(negedge clk);
        up_valid = 1'b0;
        // R9 / R10
        if (tk && m_ctr[cidx] != 2'b11) m_ctr[cidx] = m_ctr[cidx] + 2'd1;
        if (!tk && m_ctr[cidx] != 2'b00) m_ctr[cidx] = m_ctr[cidx] - 2'd1;
        if (m_vld[s] && m_tag[s] == pc[17:10]) begin
            m_hist[s] = {m_hist[s][4:0], tk};  // R7
        end else begin
            m_vld[s] = 1'b1; m_tag[s] = pc[17:10]; m_hist[s] = {5'd0, tk};  // R8
        end
    endtask

    // monitor: compares each result against the oldest expectation
    initial begin
        forever begin
            @(negedge clk);
            if (pr_valid) begin
                if (q.size() == 0) begin
                    check(1'b0, "R2", "unexpected pr_valid", "none");
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(pr_taken === e.taken && pr_hit === e.hit && pr_cidx === e.cidx, e.req,
                          $sformatf("t%0b h%0b i%0d", pr_taken, pr_hit, pr_cidx),
                          $sformatf("t%0b h%0b i%0d", e.taken, e.hit, e.cidx));
                end
            end
        end
    end

    task automatic run_tests();
        logic [7:0] c;
        logic [7:0] cp;
        logic [17:0] pa, pp, pq, pr, pl;
        for (int i = 0; i < 1024; i++) begin m_vld[i] = 0; m_tag[i] = 0; m_hist[i] = 0; end
        for (int i = 0; i < CTR_N; i++) m_ctr[i] = 2'b10;  // R1
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(pr_valid === 1'b0, "R1", $sformatf("%0b", pr_valid), "0");

        pa = {8'h03, 10'd5};
        lookup(pa, 1'b0, "R4 miss", c);                 // cidx 1, not taken
        resolve(pa, 1'b1, c);                            // R8 allocate, R9
        lookup(pa, 1'b0, "R3 R1 hit weakly taken", c);   // cidx 5, taken
        resolve(pa, 1'b0, c);
        lookup(pa, 1'b0, "R7 R5 shifted history", c);    // hist 000010

        // saturation observed through branch P, trained via branch Q (R11)
        pp = {8'h01, 10'd7};
        pq = {8'h09, 10'd300};
        resolve(pp, 1'b1, m_index(6'd0, pp, 1'b0));
        lookup(pp, 1'b0, "R3", cp);                      // cidx {000001,11}=7
        for (int i = 0; i < 3; i++) resolve(pq, 1'b1, cp);
        resolve(pq, 1'b0, cp);
        lookup(pp, 1'b0, "R9 saturate high", c, 1);
        for (int i = 0; i < 4; i++) resolve(pq, 1'b0, cp);
        resolve(pq, 1'b1, cp);
        lookup(pp, 1'b0, "R10 saturate low", c, 0);
        // stale index: P's history moves, old index still trained
        resolve(pp, 1'b1, cp);
        resolve(pp, 1'b1, cp);
        resolve(pp, 1'b1, cp);
        lookup(pp, 1'b0, "R11 stale index trained", c);
        for (int i = 0; i < 4; i++) resolve(pq, 1'b0, 8'd0);
        check(m_ctr[cp] == 2'b11, "R11", $sformatf("%0d", m_ctr[cp]), "3");

        // XOR mode
        lookup(pp, 1'b1, "R6 xor index", c);
        resolve(pp, 1'b0, c);
        lookup(pp, 1'b1, "R6 xor after train", c);

        // aliasing in set 7
        pr = {8'h02, 10'd7};
        lookup(pr, 1'b0, "R4 alias miss", c);
        resolve(pr, 1'b1, c);
        lookup(pr, 1'b0, "R8 alias claimed", c);
        lookup(pp, 1'b0, "R8 old branch replaced", c);

        // period-4 pattern 0,0,0,1
        pl = {8'h05, 10'd100};
        for (int it = 0; it < 64; it++) begin
            logic tk;
            tk = (it % 4) == 3;
            if (it >= 32) lookup(pl, 1'b0, "R12 learned pattern", c, int'(tk));
            else          lookup(pl, 1'b0, "R12 warmup", c);
            resolve(pl, tk, c);
        end
        repeat (3) @(negedge clk);
        check(q.size() == 0, "R2", $sformatf("%0d pending", q.size()), "0 pending");
    endtask

    initial begin
        fork
            run_tests();
            begin
                repeat (200000) @(posedge clk);
                check(1'b0, "watchdog", "timeout", "done");
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule